// File: doc/BRIEF.md
# Subroutine Call and Return Unit

This block steers the program counter for the branch-to-subroutine and return-from-subroutine instruction class. A caller presents one instruction at a time. The instruction is given as an opcode byte, two operand bytes that carry the low and then the high half of the target, the current carry flag, and the program counter of the instruction. The unit decides whether the instruction executes. A call that executes saves the return address on a byte-wide stack and jumps to the target. A return that executes restores the program counter from the stack. An instruction that does not execute simply steps past itself.

The stack lives inside the block as a small byte memory, indexed by the low bits of a 16-bit stack pointer. A push first lowers the pointer and then stores. A pop first reads and then raises the pointer. Before the first call, the pointer is loaded through a dedicated load strobe. A completed instruction is marked by a one-cycle `done` pulse. During that pulse, `pc_out` holds the next program counter and `taken` tells whether the instruction executed.

Top module: `subcall_unit`

## Requirements
- R1: After reset, `ready` is 1. `done` and `taken` are 0. `pc_out` is 0, and `sp_out` equals the parameter `SP_RESET`, which defaults to 0.
- R2: When the unit is idle and `sp_load` is high, `sp_out` equals `sp_init` one cycle later. `sp_load` wins over a simultaneous `op_valid`: that instruction is dropped and no `done` follows.
- R3: Opcode encoding: 8'h01 is an unconditional call and 8'h05 an unconditional return. 8'h02 calls and 8'h06 returns only when carry is 1. 8'h03 calls and 8'h07 returns only when carry is 0. Any other value is ignored: no `done` pulse, and neither `pc_out` nor `sp_out` changes.
- R4: An executed call gives `done` three cycles after acceptance, with `taken`=1, `pc_out` = {`op_hi`,`op_lo`} and `sp_out` lowered by 2.
- R5: The return address saved by a call is `pc_in`+3, modulo 2^16. Its high byte goes to address sp-1 and its low byte to sp-2, where sp is the pointer before the call. Pointer arithmetic wraps modulo 2^16.
- R6: An executed return gives `done` three cycles after acceptance, with `taken`=1, `pc_out` = {byte at sp+1, byte at sp} and `sp_out` raised by 2.
- R7: A conditional call or return executes exactly when its carry condition from R3 holds.
- R8: A call that does not execute gives `done` one cycle after acceptance, with `taken`=0, `pc_out` = `pc_in`+3 (mod 2^16), and `sp_out` unchanged.
- R9: A return that does not execute gives `done` one cycle after acceptance, with `taken`=0, `pc_out` = `pc_in`+1 (mod 2^16), and `sp_out` unchanged.
- R10: For nested calls, each executed return restores the return address of the most recent call that has not yet been matched.
- R11: While an instruction is in progress, `ready` is 0, and `op_valid` and `sp_load` have no effect. `done` is only ever raised while `ready` is 1.
- R12: `taken` is high only during a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| sp_load | input | 1 | Load the stack pointer from `sp_init` |
| sp_init | input | 16 | New stack pointer value |
| op_valid | input | 1 | Instruction presented this cycle |
| op_code | input | 8 | Opcode byte |
| op_lo | input | 8 | First operand byte, low half of the target |
| op_hi | input | 8 | Second operand byte, high half of the target |
| carry | input | 1 | Current carry flag |
| pc_in | input | 16 | Address of the presented instruction |
| ready | output | 1 | Unit idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Instruction executed (valid with `done`) |
| pc_out | output | 16 | Next program counter |
| sp_out | output | 16 | Current stack pointer |

## Verification
Each conditional opcode is tried with both carry values. This separates the executed path (three cycles, stack moves) from the skipped path (one cycle, pointer untouched, advance of 3 or 1), and it catches a swapped condition. Nested calls followed by returns show whether the stack is last-in-first-out. A return that is made from a deliberately shifted pointer straddles two saved addresses, which shows which byte of each address went to which location. Program counters near 16'hFFFF and a pointer near zero check the wrap. Random mixes of all six kinds and stray codes, interleaved with pointer loads, and noise on the inputs while the unit is busy, check the ignore rules.

// File: rtl/subcall_pkg.sv
package subcall_pkg;

  localparam int OP_W = 8;

  // local opcode encoding
  localparam logic [OP_W-1:0] OPC_CALL    = 8'h01;
  localparam logic [OP_W-1:0] OPC_CALL_CS = 8'h02;
  localparam logic [OP_W-1:0] OPC_CALL_CC = 8'h03;
  localparam logic [OP_W-1:0] OPC_RET     = 8'h05;
  localparam logic [OP_W-1:0] OPC_RET_CS  = 8'h06;
  localparam logic [OP_W-1:0] OPC_RET_CC  = 8'h07;

  typedef enum logic [2:0] {
    K_NONE, K_CALL, K_CALL_CS, K_CALL_CC, K_RET, K_RET_CS, K_RET_CC
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_POP_LO, ST_POP_HI
  } seq_state_e;

  typedef struct packed {
    logic legal;
    logic is_call;
    logic exec;
  } dec_t;

endpackage

// File: rtl/subcall_decode.sv
module subcall_decode
  import subcall_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  input  logic            carry,
  output dec_t            dec
);

  kind_e kind;

  always_comb begin
    unique case (op_code)
      OPC_CALL:    kind = K_CALL;
      OPC_CALL_CS: kind = K_CALL_CS;
      OPC_CALL_CC: kind = K_CALL_CC;
      OPC_RET:     kind = K_RET;
      OPC_RET_CS:  kind = K_RET_CS;
      OPC_RET_CC:  kind = K_RET_CC;
      default:     kind = K_NONE;
    endcase
  end

  always_comb begin
    dec.legal   = (kind != K_NONE);
    dec.is_call = (kind == K_CALL) || (kind == K_CALL_CS) || (kind == K_CALL_CC);
    unique case (kind)
      K_CALL, K_RET:       dec.exec = 1'b1;
      K_CALL_CS, K_RET_CS: dec.exec = carry;
      K_CALL_CC, K_RET_CC: dec.exec = ~carry;
      default:             dec.exec = 1'b0;
    endcase
  end

endmodule

// File: rtl/subcall_stack_ram.sv
module subcall_stack_ram #(
  parameter int BW     = 8,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/subcall_seq.sv
module subcall_seq
  import subcall_pkg::*;
#(
  parameter int                 BW       = 8,
  parameter int                 RAM_AW   = 8,
  parameter logic [2*BW-1:0]    SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_load,
  input  logic [2*BW-1:0]   sp_init,
  input  logic              op_valid,
  input  dec_t              dec,
  input  logic [BW-1:0]     op_lo,
  input  logic [BW-1:0]     op_hi,
  input  logic [2*BW-1:0]   pc_in,
  input  logic [BW-1:0]     ram_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [BW-1:0]     ram_wdata,
  output logic              ready,
  output logic              done,
  output logic              taken,
  output logic [2*BW-1:0]   pc_out,
  output logic [2*BW-1:0]   sp_out
);

  localparam int              PC_W     = 2 * BW;
  localparam logic [PC_W-1:0] LEN_CALL = PC_W'(3);
  localparam logic [PC_W-1:0] LEN_RET  = PC_W'(1);
  localparam logic [PC_W-1:0] ONE      = PC_W'(1);

  seq_state_e      state_q, state_d;
  logic [PC_W-1:0] sp_q, sp_d, pc_q, pc_d, ret_q, ret_d, tgt_q, tgt_d;
  logic [BW-1:0]   lo_q, lo_d;
  logic            done_q, done_d, taken_q, taken_d;
  logic            sp_en, pc_en, cap_en, lo_en;
  logic [PC_W-1:0] sp_dec, sp_inc;
  logic            accept;

  assign sp_dec = sp_q - ONE;
  assign sp_inc = sp_q + ONE;
  assign accept = (state_q == ST_IDLE) && op_valid && !sp_load && dec.legal;

  // next-state process
  always_comb begin
    state_d   = state_q;
    sp_d      = sp_q;
    pc_d      = pc_q;
    ret_d     = pc_in + LEN_CALL;
    tgt_d     = {op_hi, op_lo};
    lo_d      = ram_rdata;
    done_d    = 1'b0;
    taken_d   = 1'b0;
    sp_en     = 1'b0;
    pc_en     = 1'b0;
    cap_en    = 1'b0;
    lo_en     = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = sp_q[RAM_AW-1:0];
    ram_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sp_load) begin
          sp_d  = sp_init;
          sp_en = 1'b1;
        end else if (accept) begin
          if (dec.exec) begin
            cap_en  = 1'b1;
            state_d = dec.is_call ? ST_PUSH_HI : ST_POP_LO;
          end else begin
            pc_d   = pc_in + (dec.is_call ? LEN_CALL : LEN_RET);
            pc_en  = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      ST_PUSH_HI: begin
        ram_we    = 1'b1;
        ram_addr  = sp_dec[RAM_AW-1:0];
        ram_wdata = ret_q[PC_W-1:BW];
        sp_d      = sp_dec;
        sp_en     = 1'b1;
        state_d   = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        ram_we    = 1'b1;
        ram_addr  = sp_dec[RAM_AW-1:0];
        ram_wdata = ret_q[BW-1:0];
        sp_d      = sp_dec;
        sp_en     = 1'b1;
        pc_d      = tgt_q;
        pc_en     = 1'b1;
        done_d    = 1'b1;
        taken_d   = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_POP_LO: begin
        lo_en   = 1'b1;
        sp_d    = sp_inc;
        sp_en   = 1'b1;
        state_d = ST_POP_HI;
      end
      ST_POP_HI: begin
        pc_d    = {ram_rdata, lo_q};
        pc_en   = 1'b1;
        sp_d    = sp_inc;
        sp_en   = 1'b1;
        done_d  = 1'b1;
        taken_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_RESET;
      pc_q    <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      taken_q <= taken_d;
      if (sp_en) sp_q <= sp_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  // datapath captures without reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      ret_q <= ret_d;
      tgt_q <= tgt_d;
    end
    if (lo_en) lo_q <= lo_d;
  end

  assign ready  = (state_q == ST_IDLE);
  assign done   = done_q;
  assign taken  = taken_q;
  assign pc_out = pc_q;
  assign sp_out = sp_q;

endmodule

// File: rtl/subcall_unit.sv
module subcall_unit
  import subcall_pkg::*;
#(
  parameter int              BW       = 8,
  parameter int              RAM_AW   = 8,
  parameter logic [2*BW-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_load,
  input  logic [2*BW-1:0] sp_init,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic [BW-1:0]   op_lo,
  input  logic [BW-1:0]   op_hi,
  input  logic            carry,
  input  logic [2*BW-1:0] pc_in,
  output logic            ready,
  output logic            done,
  output logic            taken,
  output logic [2*BW-1:0] pc_out,
  output logic [2*BW-1:0] sp_out
);

  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  dec_t              dec;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [BW-1:0]     ram_wdata, ram_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  subcall_decode u_dec (
    .op_code (op_code),
    .carry   (carry),
    .dec     (dec)
  );

  subcall_seq #(
    .BW       (BW),
    .RAM_AW   (RAM_AW),
    .SP_RESET (SP_RESET)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .sp_load   (sp_load),
    .sp_init   (sp_init),
    .op_valid  (op_valid),
    .dec       (dec),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .pc_in     (pc_in),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ready     (ready),
    .done      (done),
    .taken     (taken),
    .pc_out    (pc_out),
    .sp_out    (sp_out)
  );

  subcall_stack_ram #(
    .BW     (BW),
    .RAM_AW (RAM_AW)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

endmodule

// File: rtl/subcall_unit_chk.sv
module subcall_unit_chk
  import subcall_pkg::*;
#(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sp_load,
  input logic [2*BW-1:0] sp_init,
  input logic            op_valid,
  input logic [OP_W-1:0] op_code,
  input logic [BW-1:0]   op_lo,
  input logic [BW-1:0]   op_hi,
  input logic            carry,
  input logic [2*BW-1:0] pc_in,
  input logic            ready,
  input logic            done,
  input logic            taken,
  input logic [2*BW-1:0] pc_out,
  input logic [2*BW-1:0] sp_out
);

  localparam int              PC_W = 2 * BW;
  localparam logic [PC_W-1:0] C1   = PC_W'(1);
  localparam logic [PC_W-1:0] C2   = PC_W'(2);
  localparam logic [PC_W-1:0] C3   = PC_W'(3);

  logic acc, known, call_skip, ret_skip;
  assign acc       = ready && op_valid && !sp_load;
  assign known     = (op_code == OPC_CALL) || (op_code == OPC_CALL_CS) ||
                     (op_code == OPC_CALL_CC) || (op_code == OPC_RET) ||
                     (op_code == OPC_RET_CS) || (op_code == OPC_RET_CC);
  assign call_skip = ((op_code == OPC_CALL_CS) && !carry) || ((op_code == OPC_CALL_CC) && carry);
  assign ret_skip  = ((op_code == OPC_RET_CS) && !carry) || ((op_code == OPC_RET_CC) && carry);

  // R2
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && sp_load |=> (sp_out == $past(sp_init)) && !done);

  // R3
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !known |=> !done && ready && $stable(sp_out) && $stable(pc_out));

  // R4
  call_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code == OPC_CALL) |=> !ready ##1 !ready ##1
    (done && taken && pc_out == {$past(op_hi, 3), $past(op_lo, 3)} &&
     sp_out == PC_W'($past(sp_out, 3) - C2)));

  // R6
  ret_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code == OPC_RET) |=> !ready ##1 !ready ##1
    (done && taken && sp_out == PC_W'($past(sp_out, 3) + C2)));

  // R8
  call_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && call_skip |=> done && !taken && ready &&
    pc_out == PC_W'($past(pc_in) + C3) && sp_out == $past(sp_out));

  // R9
  ret_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ret_skip |=> done && !taken && ready &&
    pc_out == PC_W'($past(pc_in) + C1) && sp_out == $past(sp_out));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  // R11
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ready) |-> (sp_out == PC_W'($past(sp_out) + C1)) ||
                      (sp_out == PC_W'($past(sp_out) - C1)));

  // R12
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> done);

endmodule

bind subcall_unit subcall_unit_chk #(.BW(BW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .sp_load  (sp_load),
  .sp_init  (sp_init),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_lo    (op_lo),
  .op_hi    (op_hi),
  .carry    (carry),
  .pc_in    (pc_in),
  .ready    (ready),
  .done     (done),
  .taken    (taken),
  .pc_out   (pc_out),
  .sp_out   (sp_out)
);

// File: tb/subcall_unit_test.sv
module subcall_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_load = 1'b0;
  logic [15:0] sp_init = '0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = '0;
  logic [7:0]  op_lo = '0;
  logic [7:0]  op_hi = '0;
  logic        carry = 1'b0;
  logic [15:0] pc_in = '0;
  logic        ready, done, taken;
  logic [15:0] pc_out, sp_out;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mdl [256];
  logic [15:0] m_sp, m_pc;
  int          depth;

  subcall_unit uut (
    .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_init(sp_init),
    .op_valid(op_valid), .op_code(op_code), .op_lo(op_lo), .op_hi(op_hi),
    .carry(carry), .pc_in(pc_in), .ready(ready), .done(done), .taken(taken),
    .pc_out(pc_out), .sp_out(sp_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // R3 encoding: 1 call, 2 call-if-carry, 3 call-if-no-carry, 4 ret, 5 ret-if-carry, 6 ret-if-no-carry
  function automatic int kind_of(input logic [7:0] op);
    case (op)
      8'h01: return 1;
      8'h02: return 2;
      8'h03: return 3;
      8'h05: return 4;
      8'h06: return 5;
      8'h07: return 6;
      default: return 0;
    endcase
  endfunction

  // R7
  function automatic bit exec_of(input int k, input logic c);
    if (k == 1 || k == 4) return 1'b1;
    if (k == 2 || k == 5) return c;
    if (k == 3 || k == 6) return !c;
    return 1'b0;
  endfunction

  task automatic load_sp(input logic [15:0] v, input bit with_op);
    @(negedge clk);
    sp_load = 1'b1; sp_init = v;
    op_valid = with_op; op_code = 8'h01; op_lo = 8'h12; op_hi = 8'h34;
    @(posedge clk); #1;
    sp_load = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    check(sp_out == v, "R2 sp load", sp_out, v);
    check(!done, "R2 no done on load", done, 0);
    @(negedge clk);
    check(!done && ready, "R2 op dropped under load", {done, ready}, 2'b01);
    m_sp = v;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                        input logic c, input logic [15:0] pc, input string rq);
    int k;
    bit ex;
    logic [15:0] ra, e_pc, e_sp;
    int lat, n;
    bit got;
    k  = kind_of(op);
    ex = exec_of(k, c);
    ra = pc + 16'd3;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_lo = lo; op_hi = hi; carry = c; pc_in = pc;
    @(posedge clk); #1;
    op_valid = 1'b0;
    if (k == 0) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(!done, {rq, " R3 unknown code no done"}, done, 0);
      end
      check(pc_out == m_pc, {rq, " R3 pc kept"}, pc_out, m_pc);
      check(sp_out == m_sp, {rq, " R3 sp kept"}, sp_out, m_sp);
      return;
    end
    if (k <= 3) begin
      if (ex) begin
        mdl[m_sp[7:0] - 8'd1] = ra[15:8];
        mdl[m_sp[7:0] - 8'd2] = ra[7:0];
        e_pc = {hi, lo}; e_sp = m_sp - 16'd2; lat = 3;
      end else begin
        e_pc = ra; e_sp = m_sp; lat = 1;
      end
    end else begin
      if (ex) begin
        e_pc = {mdl[m_sp[7:0] + 8'd1], mdl[m_sp[7:0]]};
        e_sp = m_sp + 16'd2; lat = 3;
      end else begin
        e_pc = pc + 16'd1; e_sp = m_sp; lat = 1;
      end
    end
    n = 0; got = 1'b0;
    while (n < 6 && !got) begin
      @(negedge clk);
      n++;
      if (done) got = 1'b1;
    end
    check(got, {rq, " done seen"}, got, 1);
    check(n == lat, {rq, " latency"}, n, lat);
    check(pc_out == e_pc, {rq, " pc_out"}, pc_out, e_pc);
    check(sp_out == e_sp, {rq, " sp_out"}, sp_out, e_sp);
    check(taken == ex, {rq, " R12 taken"}, taken, ex);
    @(negedge clk);
    check(!taken && !done, {rq, " R12 pulse ends"}, {taken, done}, 0);
    m_pc = e_pc;
    m_sp = e_sp;
  endtask

  // R11: noise on all inputs while a call is in progress
  task automatic busy_call(input logic [15:0] pc, input logic [15:0] tgt);
    logic [15:0] ra;
    ra = pc + 16'd3;
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'h01; op_lo = tgt[7:0]; op_hi = tgt[15:8]; carry = 1'b0; pc_in = pc;
    @(posedge clk); #1;
    op_code = 8'h05; sp_load = 1'b1; sp_init = 16'h1111;
    @(negedge clk);
    check(!ready, "R11 ready low while busy", ready, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    op_valid = 1'b0; sp_load = 1'b0;
    @(negedge clk);
    check(done && pc_out == tgt, "R11 busy inputs ignored pc", pc_out, tgt);
    check(sp_out == m_sp - 16'd2, "R11 busy inputs ignored sp", sp_out, m_sp - 16'd2);
    mdl[m_sp[7:0] - 8'd1] = ra[15:8];
    mdl[m_sp[7:0] - 8'd2] = ra[7:0];
    m_sp = m_sp - 16'd2;
    m_pc = tgt;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] op;
    logic       c;
    int         k;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ready && !done && !taken, "R1 reset flags", {ready, done, taken}, 3'b100);
    check(pc_out == 16'h0000, "R1 reset pc", pc_out, 0);
    check(sp_out == 16'h0000, "R1 reset sp", sp_out, 0);
    m_sp = 16'h0000; m_pc = 16'h0000;

    load_sp(16'h2099, 1'b1);

    // R4 R5 R6 basic pair
    run_op(8'h01, 8'h40, 8'h30, 1'b0, 16'h2000, "R4 call");
    run_op(8'h05, 8'hAA, 8'hBB, 1'b0, 16'h3040, "R6 ret");
    check(pc_out == 16'h2003, "R5 return address", pc_out, 16'h2003);

    // R7 R8 R9 both carry values on each conditional
    run_op(8'h02, 8'h00, 8'h50, 1'b0, 16'h2100, "R8 call-if-carry skip");
    run_op(8'h03, 8'h00, 8'h50, 1'b1, 16'h2200, "R8 call-if-no-carry skip");
    run_op(8'h02, 8'h10, 8'h50, 1'b1, 16'h2300, "R7 call-if-carry exec");
    run_op(8'h06, 8'h00, 8'h00, 1'b0, 16'h5010, "R9 ret-if-carry skip");
    run_op(8'h07, 8'h00, 8'h00, 1'b1, 16'h5011, "R9 ret-if-no-carry skip");
    run_op(8'h06, 8'h00, 8'h00, 1'b1, 16'h5012, "R7 ret-if-carry exec");
    check(pc_out == 16'h2303, "R7 restored", pc_out, 16'h2303);
    run_op(8'h03, 8'h20, 8'h60, 1'b0, 16'h2400, "R7 call-if-no-carry exec");
    run_op(8'h07, 8'h00, 8'h00, 1'b0, 16'h6020, "R7 ret-if-no-carry exec");

    // R3 unknown codes
    run_op(8'h04, 8'h11, 8'h22, 1'b0, 16'h7000, "R3 code 04");
    run_op(8'h81, 8'h11, 8'h22, 1'b1, 16'h7001, "R3 code 81");
    run_op(8'h00, 8'h11, 8'h22, 1'b1, 16'h7002, "R3 code 00");

    // R8 R9 wrap of the program counter
    run_op(8'h02, 8'h00, 8'h00, 1'b0, 16'hFFFE, "R8 wrap skip");
    check(pc_out == 16'h0001, "R8 wrap value", pc_out, 16'h0001);
    run_op(8'h06, 8'h00, 8'h00, 1'b0, 16'hFFFF, "R9 wrap skip");
    check(pc_out == 16'h0000, "R9 wrap value", pc_out, 16'h0000);

    // R5 pointer wrap and wrapped return address
    load_sp(16'h0001, 1'b0);
    run_op(8'h01, 8'h77, 8'h66, 1'b0, 16'hFFFE, "R5 wrap call");
    run_op(8'h05, 8'h00, 8'h00, 1'b0, 16'h6677, "R5 wrap ret");
    check(pc_out == 16'h0001 && sp_out == 16'h0001, "R5 wrap restore", pc_out, 16'h0001);

    // R10 nesting
    load_sp(16'h4000, 1'b0);
    run_op(8'h01, 8'h00, 8'hA0, 1'b0, 16'h1000, "R10 call 1");
    run_op(8'h01, 8'h00, 8'hB0, 1'b0, 16'hA010, "R10 call 2");
    run_op(8'h01, 8'h00, 8'hC0, 1'b0, 16'hB020, "R10 call 3");
    run_op(8'h05, 8'h00, 8'h00, 1'b0, 16'hC005, "R10 ret 3");
    check(pc_out == 16'hB023, "R10 innermost first", pc_out, 16'hB023);
    run_op(8'h05, 8'h00, 8'h00, 1'b0, 16'hB030, "R10 ret 2");
    check(pc_out == 16'hA013, "R10 middle", pc_out, 16'hA013);
    run_op(8'h05, 8'h00, 8'h00, 1'b0, 16'hA040, "R10 ret 1");
    check(pc_out == 16'h1003 && sp_out == 16'h4000, "R10 outermost", pc_out, 16'h1003);

    // R5 byte placement: return from a shifted pointer straddles two saved addresses
    load_sp(16'h3000, 1'b0);
    run_op(8'h01, 8'h00, 8'h90, 1'b0, 16'h1234, "R5 call A");
    run_op(8'h01, 8'h00, 8'h91, 1'b0, 16'h5678, "R5 call B");
    load_sp(16'h2FFD, 1'b0);
    run_op(8'h05, 8'h00, 8'h00, 1'b0, 16'h9100, "R5 straddle ret");
    check(pc_out == 16'h3756, "R5 lo of A above hi of B", pc_out, 16'h3756);

    // R11
    load_sp(16'h2000, 1'b0);
    busy_call(16'h0100, 16'h0800);

    // random mix
    load_sp(16'h8000, 1'b0);
    depth = 0;
    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(0, 7))
        0: op = 8'h01;
        1: op = 8'h02;
        2: op = 8'h03;
        3: op = 8'h05;
        4: op = 8'h06;
        5: op = 8'h07;
        6: op = 8'h06;
        default: op = ($urandom_range(0, 1) == 0) ? 8'h04 : 8'hC3;
      endcase
      c = 1'($urandom_range(0, 1));
      k = kind_of(op);
      if (k >= 4 && exec_of(k, c) && depth == 0) op = 8'h01;
      if (k >= 1 && k <= 3 && exec_of(k, c) && depth >= 100) op = 8'h05;
      k = kind_of(op);
      run_op(op, 8'($urandom), 8'($urandom), c, 16'($urandom), "R7 random");
      if (exec_of(k, c)) depth = (k <= 3) ? depth + 1 : depth - 1;
    end

    finish_run();
  end

endmodule